// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block moves a programmed block of words between one peripheral controller and memory, so the processor does not touch each word. Software writes a starting memory address, a word count and a control word holding the direction, the bus policy and a burst length; a set start bit launches the transfer. The engine first waits until the peripheral reports that it is ready. It then asks the system arbiter for the bus. Once the bus is granted, it presents one memory address and a direction for each word and asks the peripheral to move that word. It advances only when the peripheral acknowledges the word.

Two bus policies are available. In cycle-stealing mode the bus is handed back after every word. In burst mode the engine keeps the bus for up to a programmed number of words. When the last word is acknowledged, a level interrupt is raised. It stays high until software writes a clear command. A count of zero finishes at once without touching the bus.

Top module: `blk_dma_engine`

## Requirements
- R1: While reset is held and right after it, bus_req, xfer_req and irq are low.
- R2: A host write with host_sel 0 loads the start address, 1 loads the word count and 2 writes control: bit 0 start, bit 1 direction (1 = device to memory), bit 2 burst mode (1) or cycle stealing (0), bits 8 and up the burst length. Direction, mode and burst length are taken from that same write.
- R3: xfer_req, and with it a non-zero mem_addr, is driven only while bus_req and bus_grant are both high.
- R4: After a start, bus_req stays low until dev_ready has been seen high.
- R5: Word k of a block (k from 0) is presented with mem_addr equal to the start address plus k, wrapping modulo the address width, and with mem_dir equal to the programmed direction. xfer_req and the address hold until xfer_ack, and each acknowledge moves exactly one word.
- R6: irq rises in the cycle after the last word's acknowledge and not before. It stays high through status writes with bit 0 clear. A write to host_sel 3 with bit 0 set lowers it in the next cycle.
- R7: In cycle-stealing mode, bus_req is low in the cycle after every acknowledged word.
- R8: In burst mode, the bus is held for burst-length words, and a burst length of 0 counts as 1. It is released after that many words or after the last word, whichever comes first. Between words of the same tenure, bus_req stays high.
- R9: A start with a word count of 0 raises irq in the next cycle and never raises bus_req.
- R10: A start written while a transfer is running is ignored. The running transfer keeps its address, count and direction, and no extra words are moved afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 status |
| host_wdata | input | HOST_W | Host write data |
| irq | output | 1 | Level completion interrupt |
| bus_req | output | 1 | Request for ownership of the system bus |
| bus_grant | input | 1 | Bus ownership granted by the arbiter |
| mem_addr | output | ADDR_W | Memory word address of the current word, zero when idle |
| mem_dir | output | 1 | 1 = device to memory, 0 = memory to device |
| dev_ready | input | 1 | Peripheral ready to begin the block |
| xfer_req | output | 1 | Per-word transfer request to the peripheral |
| xfer_ack | input | 1 | Peripheral acknowledge: the word has been moved |

## Verification
A corrupted address or count register shows up at the next acknowledge, as a wrong mem_addr or a word count that differs from the programmed one. It also moves the interrupt early or late relative to the final acknowledge. A bad tenure counter or a bad state transition shows one cycle after an acknowledge, as bus_req staying high or dropping at the wrong word. The scoreboard holds one expected entry per word, covering address, direction and whether the bus must be released. Every acknowledge is therefore compared, with no gap, against what the programmed values imply.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_ARB,
    ST_XFER,
    ST_GAP,
    ST_REL
  } seq_state_e;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_STAT  = 2'd3
  } reg_sel_e;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_DIR_BIT   = 1;
  localparam int CTRL_BURST_BIT = 2;
  localparam int CTRL_BLEN_LSB  = 8;
  localparam int STAT_CLR_BIT   = 0;

  typedef struct packed {
    logic to_mem;
    logic burst;
  } xfer_mode_t;

endpackage

// File: rtl/blk_dma_regs.sv
module blk_dma_regs
  import blk_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int BL_W   = 6,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              busy,
  input  logic              block_done,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [CNT_W-1:0]  prog_count,
  output xfer_mode_t        go_mode,
  output logic [BL_W-1:0]   go_blen,
  output logic              start_wr,
  output logic              start_go,
  output logic              irq_clear,
  output logic              irq
);

  reg_sel_e sel;
  logic     wr_addr;
  logic     wr_count;
  logic     wr_ctrl;
  logic     wr_stat;
  logic     wdata_unused;

  assign sel      = reg_sel_e'(host_sel);
  assign wr_addr  = host_we && (sel == SEL_ADDR);
  assign wr_count = host_we && (sel == SEL_COUNT);
  assign wr_ctrl  = host_we && (sel == SEL_CTRL);
  assign wr_stat  = host_we && (sel == SEL_STAT);

  // start request and the one that is actually taken
  assign start_wr  = wr_ctrl && host_wdata[CTRL_START_BIT];
  assign start_go  = start_wr && !busy;
  assign irq_clear = wr_stat && host_wdata[STAT_CLR_BIT];

  // transfer settings come straight from the start write
  assign go_mode.to_mem = host_wdata[CTRL_DIR_BIT];
  assign go_mode.burst  = host_wdata[CTRL_BURST_BIT];
  assign go_blen        = host_wdata[CTRL_BLEN_LSB +: BL_W];

  assign wdata_unused = ^host_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_addr  <= '0;
      prog_count <= '0;
      irq        <= 1'b0;
    end else begin
      if (wr_addr)  prog_addr  <= host_wdata[ADDR_W-1:0];
      if (wr_count) prog_count <= host_wdata[CNT_W-1:0];
      if (block_done)     irq <= 1'b1;
      else if (irq_clear) irq <= 1'b0;
    end
  end

endmodule

// File: rtl/blk_dma_track.sv
module blk_dma_track
  import blk_dma_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 12,
  parameter int BL_W     = 6,
  parameter bit BURST_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [CNT_W-1:0]  prog_count,
  input  xfer_mode_t        go_mode,
  input  logic [BL_W-1:0]   go_blen,
  input  logic              word_done,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  remaining,
  output xfer_mode_t        mode_q,
  output logic              last_word,
  output logic              zero_count,
  output logic              tenure_end
);

  localparam int POS_W = BL_W + 1;

  function automatic logic [ADDR_W-1:0] addr_after(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] count_after(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  // true when the word now being moved closes the current bus tenure
  function automatic logic tenure_reached(input logic [BL_W-1:0] pos,
                                          input logic [BL_W-1:0] len,
                                          input logic            burst);
    logic [POS_W-1:0] lim;
    logic [POS_W-1:0] nxt;
    lim = (len == '0) ? POS_W'(1) : {1'b0, len};
    nxt = {1'b0, pos} + POS_W'(1);
    return !burst || (nxt >= lim);
  endfunction

  assign last_word  = (remaining == CNT_W'(1));
  assign zero_count = (prog_count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      remaining <= '0;
      mode_q    <= '0;
    end else if (start_go) begin
      cur_addr      <= prog_addr;
      remaining     <= prog_count;
      mode_q.to_mem <= go_mode.to_mem;
      mode_q.burst  <= BURST_EN ? go_mode.burst : 1'b0;
    end else if (word_done) begin
      cur_addr  <= addr_after(cur_addr);
      remaining <= count_after(remaining);
    end
  end

  generate
    if (BURST_EN) begin : g_burst
      logic [BL_W-1:0] pos_q;
      logic [BL_W-1:0] blen_q;

      assign tenure_end = tenure_reached(pos_q, blen_q, mode_q.burst);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pos_q  <= '0;
          blen_q <= '0;
        end else if (start_go) begin
          pos_q  <= '0;
          blen_q <= go_blen;
        end else if (word_done) begin
          pos_q <= tenure_end ? '0 : pos_q + BL_W'(1);
        end
      end
    end else begin : g_steal_only
      logic blen_unused;
      assign blen_unused = ^go_blen;
      assign tenure_end  = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/blk_dma_seq.sv
module blk_dma_seq
  import blk_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_go,
  input  logic zero_count,
  input  logic dev_ready,
  input  logic bus_grant,
  input  logic xfer_ack,
  input  logic last_word,
  input  logic tenure_end,
  output logic bus_req,
  output logic xfer_req,
  output logic word_done,
  output logic block_done,
  output logic busy,
  output logic wait_ready
);

  seq_state_e state_q;
  seq_state_e state_d;

  always_comb begin
    state_d    = state_q;
    word_done  = 1'b0;
    block_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_go) begin
          if (zero_count) block_done = 1'b1;
          else            state_d    = ST_READY;
        end
      end
      ST_READY: if (dev_ready) state_d = ST_ARB;
      ST_ARB:   if (bus_grant) state_d = ST_XFER;
      ST_XFER: begin
        if (bus_grant && xfer_ack) begin
          word_done = 1'b1;
          if (last_word) begin
            block_done = 1'b1;
            state_d    = ST_IDLE;
          end else if (tenure_end) begin
            state_d = ST_REL;
          end else begin
            state_d = ST_GAP;
          end
        end
      end
      ST_GAP:  state_d = ST_XFER;
      ST_REL:  if (!bus_grant) state_d = ST_ARB;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign bus_req    = (state_q == ST_ARB) || (state_q == ST_XFER) || (state_q == ST_GAP);
  assign xfer_req   = (state_q == ST_XFER) && bus_grant;
  assign busy       = (state_q != ST_IDLE);
  assign wait_ready = (state_q == ST_READY);

endmodule

// File: rtl/blk_dma_engine.sv
module blk_dma_engine
  import blk_dma_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 12,
  parameter int BL_W     = 6,
  parameter int HOST_W   = 32,
  parameter bit BURST_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_dir,
  input  logic              dev_ready,
  output logic              xfer_req,
  input  logic              xfer_ack
);

  logic [ADDR_W-1:0] prog_addr;
  logic [CNT_W-1:0]  prog_count;
  xfer_mode_t        go_mode;
  logic [BL_W-1:0]   go_blen;
  logic              start_wr;
  logic              start_go;
  logic              irq_clear;
  logic              busy;
  logic              block_done;
  logic              word_done;
  logic              wait_ready;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  remaining;
  xfer_mode_t        mode_q;
  logic              last_word;
  logic              zero_count;
  logic              tenure_end;
  logic              burst_on;

  blk_dma_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BL_W(BL_W), .HOST_W(HOST_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .busy       (busy),
    .block_done (block_done),
    .prog_addr  (prog_addr),
    .prog_count (prog_count),
    .go_mode    (go_mode),
    .go_blen    (go_blen),
    .start_wr   (start_wr),
    .start_go   (start_go),
    .irq_clear  (irq_clear),
    .irq        (irq)
  );

  blk_dma_track #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BL_W(BL_W), .BURST_EN(BURST_EN)
  ) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_go   (start_go),
    .prog_addr  (prog_addr),
    .prog_count (prog_count),
    .go_mode    (go_mode),
    .go_blen    (go_blen),
    .word_done  (word_done),
    .cur_addr   (cur_addr),
    .remaining  (remaining),
    .mode_q     (mode_q),
    .last_word  (last_word),
    .zero_count (zero_count),
    .tenure_end (tenure_end)
  );

  blk_dma_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_go   (start_go),
    .zero_count (zero_count),
    .dev_ready  (dev_ready),
    .bus_grant  (bus_grant),
    .xfer_ack   (xfer_ack),
    .last_word  (last_word),
    .tenure_end (tenure_end),
    .bus_req    (bus_req),
    .xfer_req   (xfer_req),
    .word_done  (word_done),
    .block_done (block_done),
    .busy       (busy),
    .wait_ready (wait_ready)
  );

  assign burst_on = mode_q.burst;
  assign mem_addr = xfer_req ? cur_addr : '0;
  assign mem_dir  = xfer_req && mode_q.to_mem;

endmodule

// File: rtl/blk_dma_engine_sva.sv
module blk_dma_engine_sva #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_grant,
  input logic              xfer_req,
  input logic              xfer_ack,
  input logic              dev_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              irq,
  input logic              irq_clear,
  input logic              word_done,
  input logic              block_done,
  input logic              start_go,
  input logic              start_wr,
  input logic              zero_count,
  input logic              busy,
  input logic              burst_on,
  input logic              last_word,
  input logic              tenure_end,
  input logic              wait_ready,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [CNT_W-1:0]  remaining
);

  p_owned_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (bus_req && bus_grant));

  p_ready_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_ready && !dev_ready) |=> !bus_req);

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> $stable(mem_addr));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (cur_addr == $past(cur_addr) + ADDR_W'(1)));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (remaining == $past(remaining) - CNT_W'(1)));

  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(block_done));

  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clear) |=> irq);

  p_steal_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !burst_on) |=> !bus_req);

  p_burst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && burst_on && !last_word && !tenure_end) |=> bus_req);

  p_zero_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_go && zero_count) |=> (irq && !bus_req && !busy));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && busy && !word_done) |=> ($stable(remaining) && $stable(cur_addr)));

endmodule

bind blk_dma_engine blk_dma_engine_sva #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_grant  (bus_grant),
  .xfer_req   (xfer_req),
  .xfer_ack   (xfer_ack),
  .dev_ready  (dev_ready),
  .mem_addr   (mem_addr),
  .irq        (irq),
  .irq_clear  (irq_clear),
  .word_done  (word_done),
  .block_done (block_done),
  .start_go   (start_go),
  .start_wr   (start_wr),
  .zero_count (zero_count),
  .busy       (busy),
  .burst_on   (burst_on),
  .last_word  (last_word),
  .tenure_end (tenure_end),
  .wait_ready (wait_ready),
  .cur_addr   (cur_addr),
  .remaining  (remaining)
);

// File: tb/blk_dma_engine_test.sv
`timescale 1ns/1ps
module blk_dma_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = 32'd0;
  logic        irq;
  logic        bus_req;
  logic        bus_grant = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_dir;
  logic        dev_ready = 1'b0;
  logic        xfer_req;
  logic        xfer_ack = 1'b0;

  int checks = 0;
  int fails = 0;
  int words = 0;
  int ack_wait = 0;
  bit grant_hold = 1'b0;
  bit ended = 1'b0;

  typedef struct {
    logic [15:0] addr;
    logic        dir;
    logic        rel;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;

  blk_dma_engine uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .irq(irq), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_dir(mem_dir), .dev_ready(dev_ready),
    .xfer_req(xfer_req), .xfer_ack(xfer_ack)
  );

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_wdata = 32'd0;
  endtask

  // arbiter, peripheral and scoreboard monitor, all acting at the falling edge
  initial begin
    int  wcnt = 0;
    bit  rel_pend = 1'b0;
    exp_t cur;
    forever begin
      @(negedge clk);
      bus_grant = bus_req && !grant_hold;
      if (rel_pend) begin
        check_eq(cur.tag, "bus_req after word", {31'd0, bus_req}, {31'd0, !cur.rel});
        rel_pend = 1'b0;
      end
      if (xfer_ack) begin
        xfer_ack = 1'b0;
      end else if (xfer_req) begin
        if (wcnt < ack_wait) begin
          wcnt++;
        end else begin
          wcnt = 0;
          xfer_ack = 1'b1;
          words++;
          if (sbq.size() == 0) begin
            checks++; fails++;
            $display("FAIL R10 unexpected word: actual addr %0h expected none", mem_addr);
          end else begin
            cur = sbq.pop_front();
            check_eq("R5", "word address", {16'd0, mem_addr}, {16'd0, cur.addr});
            check_eq("R5", "word direction", {31'd0, mem_dir}, {31'd0, cur.dir});
            check_eq("R6", "irq before last ack", {31'd0, irq}, 32'd0);
            rel_pend = 1'b1;
          end
        end
      end
    end
  end

  task automatic run_block(input logic [15:0] addr, input int cnt, input bit dir,
                           input bit burst, input int blen, input int await,
                           input int hold, input bit interfere);
    int eff;
    exp_t e;
    eff = (blen == 0) ? 1 : blen;
    for (int k = 0; k < cnt; k++) begin
      e.addr = addr + 16'(k);
      e.dir  = dir;
      e.rel  = !burst || (((k + 1) % eff) == 0) || (k == cnt - 1);
      e.tag  = burst ? "R8" : "R7";
      sbq.push_back(e);
    end
    words = 0;
    ack_wait = await;
    dev_ready = 1'b0;
    grant_hold = (hold > 0);
    host_write(2'd0, {16'd0, addr});
    host_write(2'd1, 32'(cnt));
    host_write(2'd2, 32'(1 | (int'(dir) << 1) | (int'(burst) << 2) | (blen << 8)));
    repeat (3) @(negedge clk);
    check_eq("R4", "bus_req before dev_ready", {31'd0, bus_req}, 32'd0);
    dev_ready = 1'b1;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      check_eq("R3", "bus_req while grant withheld", {31'd0, bus_req}, 32'd1);
      check_eq("R3", "xfer_req without grant", {31'd0, xfer_req}, 32'd0);
      grant_hold = 1'b0;
    end
    if (interfere) begin
      for (int i = 0; i < 500 && words < 1; i++) @(negedge clk);
      host_write(2'd0, 32'h0000_0F00);
      host_write(2'd1, 32'd7);
      host_write(2'd2, 32'h0000_0205);
    end
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    check_eq("R6", "irq at completion", {31'd0, irq}, 32'd1);
    check_eq("R6", "words moved", 32'(words), 32'(cnt));
    check_eq("R5", "scoreboard drained", 32'(sbq.size()), 32'd0);
    repeat (5) begin
      @(negedge clk);
      check_eq("R10", "bus idle after block", {31'd0, bus_req}, 32'd0);
    end
    dev_ready = 1'b0;
    host_write(2'd3, 32'd0);
    check_eq("R6", "irq kept by write without clear bit", {31'd0, irq}, 32'd1);
    host_write(2'd3, 32'd1);
    check_eq("R6", "irq cleared", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    check_eq("R1", "bus_req in reset", {31'd0, bus_req}, 32'd0);
    check_eq("R1", "xfer_req in reset", {31'd0, xfer_req}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "irq after reset", {31'd0, irq}, 32'd0);
    check_eq("R1", "bus_req after reset", {31'd0, bus_req}, 32'd0);

    // R2 R7: cycle stealing, device to memory
    run_block(16'h0040, 5, 1'b1, 1'b0, 0, 0, 0, 1'b0);
    // R8: burst of 4 over 10 words, memory to device
    run_block(16'h1230, 10, 1'b0, 1'b1, 4, 1, 0, 1'b0);
    // R8: count an exact multiple of the burst length
    run_block(16'h2000, 6, 1'b1, 1'b1, 3, 2, 0, 1'b0);
    // R8: burst length 0 behaves as 1
    run_block(16'h3000, 3, 1'b0, 1'b1, 0, 0, 0, 1'b0);
    // R8: burst longer than the block
    run_block(16'h4000, 5, 1'b1, 1'b1, 20, 0, 0, 1'b0);
    // R3: grant withheld for a while
    run_block(16'h5000, 2, 1'b0, 1'b0, 0, 0, 6, 1'b0);
    // R5: address wraps
    run_block(16'hFFFE, 3, 1'b1, 1'b1, 2, 1, 0, 1'b0);
    // R10: start and register writes while busy
    run_block(16'h0100, 4, 1'b1, 1'b0, 0, 2, 0, 1'b1);

    // R9: zero count
    dev_ready = 1'b1;
    host_write(2'd1, 32'd0);
    host_write(2'd2, 32'h0000_0001);
    check_eq("R9", "irq after zero-count start", {31'd0, irq}, 32'd1);
    repeat (6) begin
      @(negedge clk);
      check_eq("R9", "no bus request for zero count", {31'd0, bus_req}, 32'd0);
    end
    host_write(2'd3, 32'd1);
    check_eq("R9", "irq cleared after zero count", {31'd0, irq}, 32'd0);
    dev_ready = 1'b0;

    ended = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule